// File: doc/BRIEF.md
# Three-Wire Register Write Port

This block accepts register writes over a three-wire serial link: an active-low select, a serial clock and a serial data line. A transfer is one 16-bit frame that the host shifts in while select is low. The frame carries a two-bit device code, a direction bit, a five-bit register address and an eight-bit value. Both fields are sent most significant bit first. The port cannot be read back. It holds a small bank of eight-bit control registers and presents all of them at once on a parallel output bus, where the surrounding logic uses them as configuration.

The serial inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and edges are detected in the system clock domain. For this to work, the system clock must run at least four times faster than the serial clock. A frame is only applied when select rises, and only if it is complete and well formed. Frames that are not are dropped. An active-low power-down input returns the whole bank to its power-on values asynchronously.

Top module: `ctlport_wr`

## Requirements
- R1: After reset the registers hold 0x8B at address 0, 0x02 at address 1, 0x00 at address 2 and 0xFF at addresses 3 and 4.
- R2: The frame is shifted in on rising serial-clock edges while select is low. Its bit order is: device code (2 bits), direction bit, address (5 bits, MSB first), data (8 bits, MSB first).
- R3: A write takes effect only after select rises. While select stays low, no register changes, even after all 16 bits have arrived.
- R4: A frame whose device code is not binary 01 changes no register.
- R5: A frame whose direction bit is 0 changes no register.
- R6: A frame that ends with more or fewer than 16 serial-clock rising edges changes no register.
- R7: Writes to addresses 5 through 31 change no register.
- R8: While the power-down input is low, all registers hold their R1 values, without waiting for a clock edge. They keep those values after it returns high.
- R9: Writes are accepted whatever value register 0 holds, including 0x00 in its two low bits.
- R10: Register k appears on output bits [8k+7:8k] of the parallel bus.
- R11: Serial-clock edges that occur while select is high are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down, restores defaults |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data |
| regs_o | output | 40 | Register bank, register k at bits [8k+7:8k] |

## Verification
A wrong shift or count state shows up as one of two symptoms at the parallel bus: a register that changes when it should not, or a register that holds a rotated or misplaced value. In both cases the effect appears within three system clocks after select rises. A decode fault shows up as a neighbouring register changing on the same cycle. A fault in power-down handling shows up at once, while the power-down input is still low, because the bus no longer matches the default image.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int FRAME_W  = 3 + ADDR_W + DATA_W;
    localparam int BANK_W   = NUM_REGS * DATA_W;
    localparam logic [1:0] DEV_CODE = 2'b01;

    typedef struct packed {
        logic [1:0]        dev;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h8B;
            1:       return 8'h02;
            3, 4:    return 8'hFF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] default_image();
        logic [BANK_W-1:0] img;
        for (int i = 0; i < NUM_REGS; i++)
            img[i*DATA_W +: DATA_W] = reg_default(i);
        return img;
    endfunction
endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
    parameter int   WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_dn_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge pwr_dn_n) begin
        if (!pwr_dn_n) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
            prev_o <= RST_VAL;
        end else if (rst) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
            prev_o <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
            prev_o <= sync_o;
        end
    end
endmodule

// File: rtl/ctlport_deser.sv
module ctlport_deser
    import ctlport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_dn_n,
    input  logic  sel_q,
    input  logic  sel_prev,
    input  logic  sck_q,
    input  logic  sck_prev,
    input  logic  sd_q,
    output logic  wr_stb,
    output wreq_t wreq
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sck_rise, sel_rise;
    frame_t             frm;

    assign sck_rise = sck_q & ~sck_prev;
    assign sel_rise = sel_q & ~sel_prev;
    assign frm      = frame_t'(shreg);

    always_ff @(posedge clk or negedge pwr_dn_n) begin
        if (!pwr_dn_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (sel_q) begin
            cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sd_q};
            if (cnt != CNT_W'(CNT_MAX))
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        wr_stb    = sel_rise && (cnt == CNT_W'(FRAME_W))
                    && (frm.dev == DEV_CODE) && frm.wr;
        wreq.addr = frm.addr;
        wreq.data = frm.data;
    end
endmodule

// File: rtl/ctlport_bank.sv
module ctlport_bank
    import ctlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn_n,
    input  logic              wr_stb,
    input  wreq_t             wreq,
    output logic [BANK_W-1:0] bank_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        logic              hit;

        assign hit = wr_stb && (wreq.addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge pwr_dn_n) begin
            if (!pwr_dn_n)
                val_q <= reg_default(g);
            else if (rst)
                val_q <= reg_default(g);
            else if (hit)
                val_q <= wreq.data;
        end

        assign bank_o[g*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/ctlport_wr.sv
module ctlport_wr
    import ctlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [BANK_W-1:0] regs_o
);
    logic [2:0]        s_now, s_prev;
    logic              wr_stb;
    wreq_t             wreq;
    logic [ADDR_W-1:0] wr_addr;

    ctlport_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn_n (pwr_dn_n),
        .async_i  ({sel_n, sclk, sdin}),
        .sync_o   (s_now),
        .prev_o   (s_prev)
    );

    ctlport_deser u_deser (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn_n (pwr_dn_n),
        .sel_q    (s_now[2]),
        .sel_prev (s_prev[2]),
        .sck_q    (s_now[1]),
        .sck_prev (s_prev[1]),
        .sd_q     (s_now[0]),
        .wr_stb   (wr_stb),
        .wreq     (wreq)
    );

    assign wr_addr = wreq.addr;

    ctlport_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn_n (pwr_dn_n),
        .wr_stb   (wr_stb),
        .wreq     (wreq),
        .bank_o   (regs_o)
    );
endmodule

// File: rtl/ctlport_wr_chk.sv
module ctlport_wr_chk
    import ctlport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn_n,
    input logic              sel_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BANK_W-1:0] regs_o
);
    // R1 and R8: power-down forces the default image
    p_pdn_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |-> regs_o == default_image());

    // R3: the bank moves only in the cycle after an accepted strobe
    p_hold_no_stb_r3: assert property (@(posedge clk) disable iff (rst || !pwr_dn_n)
        !$past(wr_stb) |-> $stable(regs_o));

    // R3: a strobe follows a high level on the select pin two cycles earlier
    p_stb_after_sel_r3: assert property (@(posedge clk) disable iff (rst || !pwr_dn_n)
        wr_stb |-> $past(sel_n, 2));

    // R7: out-of-range address leaves the bank untouched
    p_out_of_range_r7: assert property (@(posedge clk) disable iff (rst || !pwr_dn_n)
        (wr_stb && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_o));
endmodule

bind ctlport_wr ctlport_wr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_dn_n (pwr_dn_n),
    .sel_n    (sel_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .regs_o   (regs_o)
);

// File: tb/ctlport_wr_bench.sv
module ctlport_wr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic [39:0] regs_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [5];

    always #5 clk = ~clk;

    ctlport_wr u_ctlport_wr (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n),
        .sel_n(sel_n), .sclk(sclk), .sdin(sdin), .regs_o(regs_o)
    );

    // addr 0..4 accepted, 5 and 31 ignored, bad device code, bad direction,
    // register 0 cleared then further writes (R9)
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        16'h6055, 16'h61A5, 16'h623C, 16'h6300, 16'h6481,
        16'h6500, 16'h7FEE, 16'h2011, 16'hE011, 16'h4011,
        16'h6000, 16'h61C3, 16'h60FC
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_defaults();
        mdl[0] = 8'h8B; mdl[1] = 8'h02; mdl[2] = 8'h00; mdl[3] = 8'hFF; mdl[4] = 8'hFF;
    endtask

    task automatic shift_bits(input logic [16:0] bits, input int n);
        sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic end_frame();
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic model_apply(input logic [15:0] f, input int n);
        if (n == 16 && f[15:14] == 2'b01 && f[13] && f[12:8] < 5)
            mdl[f[12:8]] = f[7:0];
    endtask

    task automatic cmp_bank(input string req);
        for (int k = 0; k < 5; k++) begin
            checks++;
            if (regs_o[k*8 +: 8] !== mdl[k]) begin
                fails++;
                $display("FAIL %s reg%0d actual %h expected %h", req, k, regs_o[k*8 +: 8], mdl[k]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        set_defaults();
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        cmp_bank("R1 reset defaults, R10 layout");

        // Table walk: R2 R4 R5 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            shift_bits({1'b0, VEC[v]}, 16);
            end_frame();
            model_apply(VEC[v], 16);
            cmp_bank("R2/R4/R5/R7/R9 vector");
        end

        // R3: complete frame with select still low must not commit
        shift_bits({1'b0, 16'h6277}, 16);
        wait_clk(10);
        cmp_bank("R3 before select rise");
        end_frame();
        model_apply(16'h6277, 16);
        cmp_bank("R3 after select rise");

        // R6: short and long frames
        shift_bits({2'b0, 15'h3066}, 15);
        end_frame();
        cmp_bank("R6 short frame");
        shift_bits({1'b1, 16'h6266}, 17);
        end_frame();
        cmp_bank("R6 long frame");

        // R11: serial clocks while select high are not counted
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; wait_clk(4);
            sclk = 1'b0; wait_clk(4);
        end
        shift_bits({1'b0, 16'h6199}, 16);
        end_frame();
        model_apply(16'h6199, 16);
        cmp_bank("R11 edges with select high ignored");

        // R8: asynchronous power-down restores defaults
        @(negedge clk);
        #2 pwr_dn_n = 1'b0;
        #1;
        set_defaults();
        cmp_bank("R8 during power-down");
        wait_clk(3);
        pwr_dn_n = 1'b1;
        wait_clk(3);
        cmp_bank("R8 after power-down");

        // R8: port usable after power-down
        shift_bits({1'b0, 16'h6312}, 16);
        end_frame();
        model_apply(16'h6312, 16);
        cmp_bank("R8 write after power-down");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule